// File: doc/BRIEF.md
# 64-bit Free-Running Global Counter

This block is a 64-bit up-counter that software reaches through a 32-bit register bus. The count is split into two 32-bit words, a low word and a high word. A third register holds control bits, and bit 0 of that register starts and stops the count. While that bit is set, the count goes up by one on every clock. A carry out of the low word moves into the high word on the same edge.

Reads are not latched across the two words, so software must rebuild a coherent 64-bit value itself. It reads the high word, then the low word, then the high word again. If the two high values differ, it reads the low and high words again. To preload a new count, software clears the enable bit, writes the low word, writes the high word, and then sets the enable bit again. Bus writes obey a per-byte strobe. The read port returns its data from a register one clock after the access.

Top module: `gcnt_top`

## Requirements
- R1: After a synchronous reset, the count, the control register and the read data are all zero, so the counter starts disabled.
- R2: Byte offset 0x00 reads and writes the low 32 bits of the count, and offset 0x04 reads and writes the high 32 bits. A read presented at a clock edge returns, on `bus_rdata` after that edge, the value the register held just before the edge.
- R3: While control bit 0 is 1 and no count word is written, the 64-bit count rises by exactly one per clock. While bit 0 is 0 and no count word is written, it holds its value.
- R4: When the low word is all ones and the counter is enabled, the low word wraps to zero and the high word rises by one on the same edge.
- R5: A write to a count word takes effect on the next edge whether or not counting is enabled. For the written word it replaces the increment.
- R6: Bit i of `bus_be` enables byte lane i, bits 8i+7 to 8i. Lanes whose strobe is 0 keep their old contents.
- R7: The control register sits at offset 0x08. All 32 of its bits are stored and read back unchanged, for example 0x5 with the counter running. Only bit 0 affects counting.
- R8: A read of any other offset returns zero, and a write to it changes no register. A misaligned offset, one whose low two bits are not zero, counts as unmapped.
- R9: `bus_rdata` keeps its last value on every cycle without a read.
- R10: Preloading with disable, low write, high write and enable, followed by the high-low-high read with retry, yields the exact 64-bit count, even when the read straddles a low-word wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 6 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte lane write strobes |
| bus_rdata | output | 32 | Registered read data |

## Verification
A fault in the count words shows up as a wrong value on the very next read of that word, one clock after the access. The bench compares every read against a cycle-accurate 64-bit model, so a missed carry or a stray increment is reported on the first read that follows it. A fault in the control register shows either as a changed readback or as a count that runs or stops against the model. A directed preload just below the low-word wrap, followed by the retry read, shows whether the carry and the retry together give the exact value.

// File: rtl/gcnt_pkg.sv
package gcnt_pkg;
  // Kind of register selected by a read access
  typedef enum logic [1:0] {
    RD_NONE    = 2'd0,
    RD_COUNT   = 2'd1,
    RD_CONTROL = 2'd2
  } rd_kind_e;

  localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/gcnt_merge.sv
module gcnt_merge #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0]               cur_i,
  input  logic [DATA_W-1:0]               wdata_i,
  input  logic [DATA_W/gcnt_pkg::LANE_W-1:0] be_i,
  output logic [DATA_W-1:0]               merged_o
);
  localparam int unsigned LANES = DATA_W / gcnt_pkg::LANE_W;
  localparam int unsigned LW    = gcnt_pkg::LANE_W;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign merged_o[b*LW +: LW] = be_i[b] ? wdata_i[b*LW +: LW] : cur_i[b*LW +: LW];
  end
endmodule

// File: rtl/gcnt_decode.sv
module gcnt_decode #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned WORDS  = 2
) (
  input  logic                     sel_i,
  input  logic                     wr_i,
  input  logic [ADDR_W-1:0]        addr_i,
  output logic [WORDS-1:0]         wr_word_o,
  output logic                     wr_ctrl_o,
  output gcnt_pkg::rd_kind_e       rd_kind_o,
  output logic [ADDR_W-3:0]        rd_word_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;

  assign idx       = addr_i[ADDR_W-1:2];
  assign aligned   = (addr_i[1:0] == 2'b00);
  assign rd_word_o = idx;

  for (genvar w = 0; w < WORDS; w++) begin : g_wsel
    assign wr_word_o[w] = sel_i && wr_i && aligned && (int'(idx) == w);
  end

  assign wr_ctrl_o = sel_i && wr_i && aligned && (int'(idx) == WORDS);

  always_comb begin
    rd_kind_o = gcnt_pkg::RD_NONE;
    if (aligned) begin
      if (int'(idx) < WORDS)       rd_kind_o = gcnt_pkg::RD_COUNT;
      else if (int'(idx) == WORDS) rd_kind_o = gcnt_pkg::RD_CONTROL;
    end
  end
endmodule

// File: rtl/gcnt_ctrl.sv
module gcnt_ctrl #(
  parameter int unsigned DATA_W = 32
) (
  input  logic                               clk_i,
  input  logic                               rst_i,
  input  logic                               wr_i,
  input  logic [DATA_W-1:0]                  wdata_i,
  input  logic [DATA_W/gcnt_pkg::LANE_W-1:0] be_i,
  output logic [DATA_W-1:0]                  ctrl_o,
  output logic                               en_o
);
  logic [DATA_W-1:0] ctrl_q, merged;

  gcnt_merge #(.DATA_W(DATA_W)) u_merge (
    .cur_i   (ctrl_q),
    .wdata_i (wdata_i),
    .be_i    (be_i),
    .merged_o(merged)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i)     ctrl_q <= '0;
    else if (wr_i) ctrl_q <= merged;
  end

  assign ctrl_o = ctrl_q;
  assign en_o   = ctrl_q[0];

  AST_CTRL_KEEP: assert property (@(posedge clk_i) disable iff (rst_i)
    !wr_i |=> $stable(ctrl_o)) else $error("ctrl changed without write"); // R7
  AST_CTRL_FULL: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_i && (&be_i)) |=> ctrl_o == $past(wdata_i)) else $error("ctrl full write lost"); // R7
endmodule

// File: rtl/gcnt_count.sv
module gcnt_count #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = 2
) (
  input  logic                               clk_i,
  input  logic                               rst_i,
  input  logic                               en_i,
  input  logic [WORDS-1:0]                   wr_word_i,
  input  logic [DATA_W-1:0]                  wdata_i,
  input  logic [DATA_W/gcnt_pkg::LANE_W-1:0] be_i,
  output logic [WORDS-1:0][DATA_W-1:0]       words_o
);
  localparam int unsigned CNT_W = DATA_W * WORDS;

  logic [WORDS-1:0]             inc;
  logic [WORDS-1:0][DATA_W-1:0] q;
  logic [CNT_W-1:0]             flat;
  logic                         any_wr;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [DATA_W-1:0] word_q, merged;

    if (w == 0) begin : g_first
      assign inc[w] = en_i;
    end else begin : g_next
      assign inc[w] = inc[w-1] & (&q[w-1]);
    end

    gcnt_merge #(.DATA_W(DATA_W)) u_merge (
      .cur_i   (word_q),
      .wdata_i (wdata_i),
      .be_i    (be_i),
      .merged_o(merged)
    );

    always_ff @(posedge clk_i) begin
      if (rst_i)              word_q <= '0;
      else if (wr_word_i[w])  word_q <= merged;
      else if (inc[w])        word_q <= word_q + 1'b1;
    end

    assign q[w] = word_q;

    AST_WORD_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
      (wr_word_i[w] && (&be_i)) |=> q[w] == $past(wdata_i)) else $error("word load lost"); // R5
  end

  assign words_o = q;
  assign flat    = q;
  assign any_wr  = |wr_word_i;

  AST_HOLD_DISABLED: assert property (@(posedge clk_i) disable iff (rst_i)
    (!en_i && !any_wr) |=> $stable(flat)) else $error("count moved while off"); // R3
  AST_STEP_ENABLED: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && !any_wr) |=> flat == $past(flat) + 1'b1) else $error("count step wrong"); // R3

  if (WORDS > 1) begin : g_carry_chk
    AST_CARRY_UP: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && !any_wr && (&q[0])) |=> (q[0] == '0) && (q[1] == $past(q[1]) + 1'b1))
      else $error("carry not taken"); // R4
  end
endmodule

// File: rtl/gcnt_top.sv
module gcnt_top #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = 2
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               bus_sel,
  input  logic                               bus_wr,
  input  logic [ADDR_W-1:0]                  bus_addr,
  input  logic [DATA_W-1:0]                  bus_wdata,
  input  logic [DATA_W/gcnt_pkg::LANE_W-1:0] bus_be,
  output logic [DATA_W-1:0]                  bus_rdata
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [WORDS-1:0]             wr_word;
  logic                         wr_ctrl, en;
  gcnt_pkg::rd_kind_e           rd_kind;
  logic [IDX_W-1:0]             rd_word;
  logic [WORDS-1:0][DATA_W-1:0] words;
  logic [DATA_W-1:0]            ctrl, rd_val, rdata_q;
  logic                         rd_go;

  gcnt_decode #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_dec (
    .sel_i    (bus_sel),
    .wr_i     (bus_wr),
    .addr_i   (bus_addr),
    .wr_word_o(wr_word),
    .wr_ctrl_o(wr_ctrl),
    .rd_kind_o(rd_kind),
    .rd_word_o(rd_word)
  );

  gcnt_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i  (clk),
    .rst_i  (rst),
    .wr_i   (wr_ctrl),
    .wdata_i(bus_wdata),
    .be_i   (bus_be),
    .ctrl_o (ctrl),
    .en_o   (en)
  );

  gcnt_count #(.DATA_W(DATA_W), .WORDS(WORDS)) u_cnt (
    .clk_i    (clk),
    .rst_i    (rst),
    .en_i     (en),
    .wr_word_i(wr_word),
    .wdata_i  (bus_wdata),
    .be_i     (bus_be),
    .words_o  (words)
  );

  always_comb begin
    rd_val = '0;
    if (rd_kind == gcnt_pkg::RD_CONTROL) rd_val = ctrl;
    else if (rd_kind == gcnt_pkg::RD_COUNT) begin
      for (int w = 0; w < WORDS; w++) begin
        if (int'(rd_word) == w) rd_val = words[w];
      end
    end
  end

  assign rd_go = bus_sel && !bus_wr;

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_go) rdata_q <= rd_val;
  end

  assign bus_rdata = rdata_q;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (words == '0) && (ctrl == '0) && (bus_rdata == '0)) else $error("reset state"); // R1
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_word, wr_ctrl})) else $error("two write targets"); // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_go && rd_kind == gcnt_pkg::RD_NONE) |=> bus_rdata == '0) else $error("unmapped read"); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_go |=> $stable(bus_rdata)) else $error("rdata moved"); // R9
endmodule

// File: tb/sim_gcnt_top.sv
`timescale 1ns/1ps
module sim_gcnt_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0, wr = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  be = '0;
  logic [31:0] rdata;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [63:0] m_cnt, m_snap;
  logic [31:0] m_ctrl, m_rd;
  logic [31:0] m_lo, m_hi, m_nlo, m_nhi;

  always #2.5 clk = ~clk;

  gcnt_top u0 (
    .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_be(be), .bus_rdata(rdata)
  );

  function automatic logic [31:0] merge32(input logic [31:0] cur, input logic [31:0] nd,
                                          input logic [3:0] strb);
    logic [31:0] r = cur;
    for (int b = 0; b < 4; b++) if (strb[b]) r[b*8 +: 8] = nd[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] model_read(input logic [5:0] a, input logic [63:0] c,
                                             input logic [31:0] k);
    case (a)
      6'h00:   return c[31:0];
      6'h04:   return c[63:32];
      6'h08:   return k;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] a);
    if (a == 6'h00 || a == 6'h04) return "R2";
    if (a == 6'h08) return "R7";
    return "R8";
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = '0; m_ctrl = '0; m_rd = '0; m_snap = '0;
    end else begin
      m_lo = m_cnt[31:0];
      m_hi = m_cnt[63:32];
      if (sel && !wr) begin
        m_rd   = model_read(addr, m_cnt, m_ctrl);
        m_snap = m_cnt;
      end
      m_nlo = m_ctrl[0] ? m_lo + 32'd1 : m_lo;
      m_nhi = (m_ctrl[0] && m_lo == 32'hFFFF_FFFF) ? m_hi + 32'd1 : m_hi;
      if (sel && wr) begin
        case (addr)
          6'h00: m_nlo  = merge32(m_lo, wdata, be);
          6'h04: m_nhi  = merge32(m_hi, wdata, be);
          6'h08: m_ctrl = merge32(m_ctrl, wdata, be);
          default: ;
        endcase
      end
      m_cnt = {m_nhi, m_nlo};
    end
  end

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // called at a negative edge; returns at the next negative edge
  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    sel = 1'b1; wr = 1'b0; addr = a; be = '0;
    @(posedge clk); @(negedge clk);
    sel = 1'b0;
    d = rdata;
    check(tag_of(a), {32'h0, d}, {32'h0, m_rd});
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d, input logic [3:0] s);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d; be = s;
    @(posedge clk); @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2, hi1, lo, hi2;
    logic [63:0] snap;
    int retries;
    void'($urandom(32'h5EED_0001));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1", {32'h0, rdata}, 64'h0);
    bus_read(6'h00, d); check("R1", {32'h0, d}, 64'h0);
    bus_read(6'h04, d); check("R1", {32'h0, d}, 64'h0);
    bus_read(6'h08, d); check("R1", {32'h0, d}, 64'h0);

    // R5/R6: writes while disabled, byte lanes
    bus_write(6'h00, 32'h1122_3344, 4'hF);
    bus_write(6'h00, 32'hAABB_CCDD, 4'b0101);
    bus_read(6'h00, d); check("R6", {32'h0, d}, 64'h0000_0000_11BB_33DD);
    bus_write(6'h04, 32'hCAFE_0001, 4'hF);
    bus_read(6'h04, d); check("R5", {32'h0, d}, 64'h0000_0000_CAFE_0001);

    // R3: hold while disabled
    bus_read(6'h00, d); bus_read(6'h00, d2); check("R3", {32'h0, d2}, {32'h0, d});

    // R7: control bits kept, counting runs
    bus_write(6'h08, 32'h0000_0005, 4'hF);
    bus_read(6'h08, d); check("R7", {32'h0, d}, 64'h5);
    bus_read(6'h00, d); bus_read(6'h00, d2); check("R3", {32'h0, d2}, {32'h0, d + 32'd1});

    // R8: unmapped and misaligned offsets
    bus_write(6'h0C, 32'hFFFF_FFFF, 4'hF);
    bus_write(6'h09, 32'h0000_0000, 4'hF);
    bus_write(6'h21, 32'h1234_5678, 4'hF);
    bus_read(6'h0C, d); check("R8", {32'h0, d}, 64'h0);
    bus_read(6'h02, d); check("R8", {32'h0, d}, 64'h0);
    bus_read(6'h08, d); check("R8", {32'h0, d}, 64'h5);

    // R9: read data held when idle
    bus_read(6'h04, d);
    @(negedge clk); @(negedge clk);
    check("R9", {32'h0, rdata}, {32'h0, d});

    // R4/R10: preload just below the wrap, then coherent read with retry
    bus_write(6'h08, 32'h0, 4'hF);
    bus_write(6'h00, 32'hFFFF_FFFE, 4'hF);
    bus_write(6'h04, 32'h0000_0005, 4'hF);
    bus_write(6'h08, 32'h1, 4'hF);
    retries = 0;
    bus_read(6'h04, hi1);
    forever begin
      bus_read(6'h00, lo);
      snap = m_snap;
      bus_read(6'h04, hi2);
      if (hi2 == hi1) break;
      hi1 = hi2;
      retries++;
    end
    check("R10", {hi2, lo}, snap);
    check("R4", {63'h0, retries >= 1}, 64'h1);
    check("R4", {32'h0, hi2}, 64'h6);

    // random traffic against the model
    for (int i = 0; i < 800; i++) begin
      logic [5:0] a;
      int pick = $urandom_range(0, 9);
      case ($urandom_range(0, 4))
        0: a = 6'h00;
        1: a = 6'h04;
        2: a = 6'h08;
        3: a = 6'h0C;
        default: a = 6'($urandom);
      endcase
      if (pick < 5) bus_read(a, d);
      else if (pick == 5) bus_write(6'h00, 32'hFFFF_FFF0 | ($urandom & 32'hF), 4'hF); // R4
      else if (pick == 6) bus_write(6'h08, $urandom | 32'h1, 4'($urandom));           // R7
      else bus_write(a, $urandom, 4'($urandom));                                     // R5 R6
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule